// File: doc/BRIEF.md
# Strided Vector Load/Store Sequencer

This block moves one vector between a word-addressed 16-bit memory and an external vector register file that holds eight registers of 63 elements each. It owns two small configuration registers: an element count and an element stride. Both are written by a move-immediate command. A start command supplies a base address, a 6-bit signed offset, a vector register number and a direction flag. The sequencer then walks the elements in ascending order. For each element it forms the memory address and issues one memory request, which it holds until the memory answers with ready.

For a load, each returned word is written into the matching element of the selected vector register. For a store, the element is read from the register file through a combinational read port and sent as write data. When the count is zero, the operation finishes at once without touching memory. A busy/done pair tells the surrounding control when the transfer has ended.

Top module: `vec_mem_seq`

## Requirements
- R1: The first element address equals the base address plus the 6-bit offset, sign-extended to 16 bits and shifted left by one, taken modulo 2^16.
- R2: Each later element address equals the previous one plus the 6-bit stride, zero-extended and shifted left by one, wrapping modulo 2^16.
- R3: With an element count of zero, an accepted start makes no memory request and raises done in the first cycle after the start edge.
- R4: A move-immediate with select 3'b000 loads its 6-bit amount into the stride register, and select 3'b001 loads it into the count register. Any other select value has no effect, and a move-immediate while busy has no effect.
- R5: A load (op_store=0) writes the word returned for element i into element index i of the selected register, with vrf_we high in the cycle mem_ready is high, for i = 0 up to count-1.
- R6: A store (op_store=1) drives mem_we=1 and mem_wdata equal to element i of the selected register for the request of element i.
- R7: Exactly one request is issued per element. mem_en, mem_we and mem_addr stay stable until mem_ready, and a transfer of L elements against a memory that completes in 5 cycles keeps busy high for 5L+1 cycles.
- R8: busy rises the cycle after an accepted start. done is high for exactly one cycle, the last busy cycle. A start while busy is ignored.
- R9: After reset, busy, done, mem_en and vrf_we are low, and both configuration registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mvi_valid | input | 1 | Move-immediate command strobe |
| mvi_sel | input | 3 | Move-immediate target select |
| mvi_amt | input | 6 | Unsigned move-immediate amount |
| start | input | 1 | Start a transfer |
| op_store | input | 1 | 1 = store, 0 = load |
| base_addr | input | 16 | Base register value |
| offset | input | 6 | Signed word offset |
| vreg_sel | input | 3 | Vector register number |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_en | output | 1 | Memory request |
| mem_we | output | 1 | Memory write flag |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data |
| mem_ready | input | 1 | Memory access complete |
| vrf_reg | output | 3 | Register file register number |
| vrf_idx | output | 6 | Register file element index |
| vrf_we | output | 1 | Register file write enable |
| vrf_wdata | output | 16 | Register file write data |
| vrf_rdata | input | 16 | Register file read data |

## Verification
The bench builds the block with its default widths: 16-bit addresses and data, 6-bit offset, stride and count, and eight registers. These defaults allow a full 63-element transfer, a start address that wraps below zero, and a maximum stride of 63 that carries addresses past 0xFFFF. The bench's memory model answers every request in its fifth cycle, so the per-element cycle budget can be checked exactly.

// File: rtl/vms_pkg.sv
package vms_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_XFER = 2'd1,
        SEQ_FIN  = 2'd2
    } seq_state_t;

    localparam logic [2:0] MVI_TO_STRIDE = 3'b000;
    localparam logic [2:0] MVI_TO_COUNT  = 3'b001;

endpackage

// File: rtl/vms_cfg.sv
module vms_cfg #(
    parameter int CNTW = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            busy,
    input  logic            mvi_valid,
    input  logic [2:0]      mvi_sel,
    input  logic [CNTW-1:0] mvi_amt,
    output logic [CNTW-1:0] stride_q,
    output logic [CNTW-1:0] count_q
);
    import vms_pkg::*;

    typedef struct packed {
        logic [CNTW-1:0] stride;
        logic [CNTW-1:0] count;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (mvi_valid && !busy) begin
            if (mvi_sel == MVI_TO_STRIDE) cfg_d.stride = mvi_amt;
            else if (mvi_sel == MVI_TO_COUNT) cfg_d.count = mvi_amt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign stride_q = cfg_q.stride;
    assign count_q  = cfg_q.count;

    // R4: configuration untouched while a transfer runs
    a_r4_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(stride_q) && $stable(count_q)));

endmodule

// File: rtl/vms_agen.sv
module vms_agen #(
    parameter int AW   = 16,
    parameter int OFFW = 6,
    parameter int CNTW = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            step,
    input  logic [AW-1:0]   base,
    input  logic [OFFW-1:0] offset,
    input  logic [CNTW-1:0] stride,
    output logic [AW-1:0]   addr_q
);
    localparam int OPAD = AW - OFFW - 1;
    localparam int SPAD = AW - CNTW - 1;

    logic [AW-1:0] addr_d;
    logic [AW-1:0] off_word;
    logic [AW-1:0] stride_word;

    assign off_word    = {{OPAD{offset[OFFW-1]}}, offset, 1'b0};
    assign stride_word = {{SPAD{1'b0}}, stride, 1'b0};

    always_comb begin
        addr_d = addr_q;
        if (load)      addr_d = base + off_word;
        else if (step) addr_d = addr_q + stride_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

endmodule

// File: rtl/vms_ctrl.sv
module vms_ctrl #(
    parameter int CNTW = 6,
    parameter int RSW  = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            op_store,
    input  logic [RSW-1:0]  vreg_sel,
    input  logic [CNTW-1:0] count,
    input  logic            mem_ready,
    output logic            busy,
    output logic            done,
    output logic            req,
    output logic            store,
    output logic            addr_load,
    output logic            addr_step,
    output logic            elem_we,
    output logic [RSW-1:0]  reg_sel,
    output logic [CNTW-1:0] elem_idx
);
    import vms_pkg::*;

    typedef struct packed {
        seq_state_t      st;
        logic [CNTW-1:0] idx;
        logic [RSW-1:0]  rsel;
        logic            wr;
    } ctrl_t;

    ctrl_t c_d, c_q;
    logic  last_elem;

    assign last_elem = (c_q.idx == count - CNTW'(1));

    always_comb begin
        c_d       = c_q;
        addr_load = 1'b0;
        addr_step = 1'b0;
        elem_we   = 1'b0;
        req       = 1'b0;
        done      = 1'b0;
        unique case (c_q.st)
            SEQ_IDLE: begin
                if (start) begin
                    c_d.rsel  = vreg_sel;
                    c_d.wr    = op_store;
                    c_d.idx   = '0;
                    addr_load = 1'b1;
                    c_d.st    = (count == '0) ? SEQ_FIN : SEQ_XFER;
                end
            end
            SEQ_XFER: begin
                req = 1'b1;
                if (mem_ready) begin
                    elem_we   = !c_q.wr;
                    addr_step = 1'b1;
                    if (last_elem) c_d.st = SEQ_FIN;
                    else           c_d.idx = c_q.idx + CNTW'(1);
                end
            end
            SEQ_FIN: begin
                done   = 1'b1;
                c_d.st = SEQ_IDLE;
            end
            default: c_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '{st: SEQ_IDLE, idx: '0, rsel: '0, wr: 1'b0};
        else        c_q <= c_d;
    end

    assign busy     = (c_q.st != SEQ_IDLE);
    assign store    = c_q.wr;
    assign reg_sel  = c_q.rsel;
    assign elem_idx = c_q.idx;

    // R3: zero count goes straight to completion without a request
    a_r3_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && count == '0) |=> (done && !req));

    // R8: done lasts a single cycle
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: a start while busy does not retarget the transfer
    a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> ($stable(reg_sel) && $stable(store)));

    // R5: element writes only for loads, only on a completed access
    a_r5_write_on_ready: assert property (@(posedge clk) disable iff (!rst_n)
        elem_we |-> (mem_ready && req && !store));

endmodule

// File: rtl/vec_mem_seq.sv
module vec_mem_seq #(
    parameter int AW   = 16,
    parameter int DW   = 16,
    parameter int OFFW = 6,
    parameter int CNTW = 6,
    parameter int NREG = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     mvi_valid,
    input  logic [2:0]               mvi_sel,
    input  logic [CNTW-1:0]          mvi_amt,
    input  logic                     start,
    input  logic                     op_store,
    input  logic [AW-1:0]            base_addr,
    input  logic [OFFW-1:0]          offset,
    input  logic [$clog2(NREG)-1:0]  vreg_sel,
    output logic                     busy,
    output logic                     done,
    output logic                     mem_en,
    output logic                     mem_we,
    output logic [AW-1:0]            mem_addr,
    output logic [DW-1:0]            mem_wdata,
    input  logic [DW-1:0]            mem_rdata,
    input  logic                     mem_ready,
    output logic [$clog2(NREG)-1:0]  vrf_reg,
    output logic [CNTW-1:0]          vrf_idx,
    output logic                     vrf_we,
    output logic [DW-1:0]            vrf_wdata,
    input  logic [DW-1:0]            vrf_rdata
);
    localparam int RSW = $clog2(NREG);

    logic [CNTW-1:0] stride_q;
    logic [CNTW-1:0] count_q;
    logic            addr_load;
    logic            addr_step;
    logic            req;
    logic            store;

    vms_cfg #(.CNTW(CNTW)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (busy),
        .mvi_valid (mvi_valid),
        .mvi_sel   (mvi_sel),
        .mvi_amt   (mvi_amt),
        .stride_q  (stride_q),
        .count_q   (count_q)
    );

    vms_agen #(.AW(AW), .OFFW(OFFW), .CNTW(CNTW)) u_agen (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (addr_load),
        .step   (addr_step),
        .base   (base_addr),
        .offset (offset),
        .stride (stride_q),
        .addr_q (mem_addr)
    );

    vms_ctrl #(.CNTW(CNTW), .RSW(RSW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .op_store  (op_store),
        .vreg_sel  (vreg_sel),
        .count     (count_q),
        .mem_ready (mem_ready),
        .busy      (busy),
        .done      (done),
        .req       (req),
        .store     (store),
        .addr_load (addr_load),
        .addr_step (addr_step),
        .elem_we   (vrf_we),
        .reg_sel   (vrf_reg),
        .elem_idx  (vrf_idx)
    );

    assign mem_en    = req;
    assign mem_we    = req && store;
    assign mem_wdata = vrf_rdata;
    assign vrf_wdata = mem_rdata;

    // R7: request held steady until the memory answers
    a_r7_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_ready) |=> (mem_en && $stable(mem_addr) && $stable(mem_we)));

    // R2: a completed non-final element advances the address by the stride
    a_r2_stride_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_ready && !(vrf_idx == count_q - CNTW'(1)))
        |=> (mem_addr == $past(mem_addr) + AW'({stride_q, 1'b0})));

    // R9: nothing requested out of idle
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_en && !vrf_we));

endmodule

// File: tb/vec_mem_seq_test.sv
module vec_mem_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mvi_valid = 1'b0;
    logic [2:0]  mvi_sel = '0;
    logic [5:0]  mvi_amt = '0;
    logic        start = 1'b0;
    logic        op_store = 1'b0;
    logic [15:0] base_addr = '0;
    logic [5:0]  offset = '0;
    logic [2:0]  vreg_sel = '0;
    logic        busy, done, mem_en, mem_we, vrf_we;
    logic [15:0] mem_addr, mem_wdata, vrf_wdata, vrf_rdata;
    logic [15:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;
    logic [2:0]  vrf_reg;
    logic [5:0]  vrf_idx;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    logic [15:0] vrf_m [8][64];
    logic [15:0] log_addr [128];
    logic [15:0] log_data [128];
    logic        log_we   [128];
    int          log_n = 0;
    int          mcnt = 0;

    always #2 clk = ~clk;

    vec_mem_seq uut (
        .clk(clk), .rst_n(rst_n), .mvi_valid(mvi_valid), .mvi_sel(mvi_sel),
        .mvi_amt(mvi_amt), .start(start), .op_store(op_store),
        .base_addr(base_addr), .offset(offset), .vreg_sel(vreg_sel),
        .busy(busy), .done(done), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .vrf_reg(vrf_reg), .vrf_idx(vrf_idx),
        .vrf_we(vrf_we), .vrf_wdata(vrf_wdata), .vrf_rdata(vrf_rdata)
    );

    function automatic logic [15:0] pat(input logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'h1234;
    endfunction

    assign vrf_rdata = vrf_m[vrf_reg][vrf_idx];

    // memory model: answers in the fifth cycle of each request
    always @(posedge clk) begin
        if (!rst_n) begin
            mcnt <= 0;
            mem_ready <= 1'b0;
        end else if (mem_en && !mem_ready) begin
            if (mcnt == 3) begin
                mem_ready <= 1'b1;
                mcnt <= 0;
                mem_rdata <= pat(mem_addr);
                if (log_n < 128) begin
                    log_addr[log_n] <= mem_addr;
                    log_data[log_n] <= mem_wdata;
                    log_we[log_n]   <= mem_we;
                end
                log_n <= log_n + 1;
            end else begin
                mcnt <= mcnt + 1;
            end
        end else begin
            mem_ready <= 1'b0;
        end
    end

    always @(posedge clk) if (vrf_we) vrf_m[vrf_reg][vrf_idx] <= vrf_wdata;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run hung, actual cycle %0d expected < 100000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic mvi(input logic [2:0] sel, input logic [5:0] amt);
        @(negedge clk);
        mvi_valid = 1'b1; mvi_sel = sel; mvi_amt = amt;
        @(negedge clk);
        mvi_valid = 1'b0;
    endtask

    // issue a start and count busy cycles up to and including done
    task automatic run(input logic st, input logic [15:0] base, input logic [5:0] off,
                       input logic [2:0] rg, output int busy_cycles);
        @(negedge clk);
        start = 1'b1; op_store = st; base_addr = base; offset = off; vreg_sel = rg;
        @(negedge clk);
        start = 1'b0;
        busy_cycles = 0;
        forever begin
            if (busy) busy_cycles++;
            if (done) break;
            @(negedge clk);
        end
        @(negedge clk);
        chk("R8 done single cycle", {31'd0, done}, 32'd0);
        chk("R8 busy drops after done", {31'd0, busy}, 32'd0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R9 busy after reset", {31'd0, busy}, 32'd0);
        chk("R9 done after reset", {31'd0, done}, 32'd0);
        chk("R9 mem_en after reset", {31'd0, mem_en}, 32'd0);
        chk("R9 vrf_we after reset", {31'd0, vrf_we}, 32'd0);
    endtask

    task automatic t_zero_count;
        int bc;
        int n0;
        n0 = log_n;
        run(1'b0, 16'h2000, 6'd0, 3'd1, bc);
        chk("R9/R3 reset count is zero, one busy cycle", bc, 1);
        chk("R3 no memory access", log_n, n0);
    endtask

    task automatic t_load(input logic [15:0] base, input logic [5:0] off,
                          input logic [5:0] strd, input logic [5:0] len, input logic [2:0] rg);
        int bc;
        int n0;
        logic [15:0] a;
        mvi(3'b000, strd);
        mvi(3'b001, len);
        n0 = log_n;
        run(1'b0, base, off, rg, bc);
        chk("R7 load busy cycles", bc, 5 * len + 1);
        chk("R7 one access per element", log_n - n0, len);
        a = base + {{9{off[5]}}, off, 1'b0};
        for (int i = 0; i < len; i++) begin
            chk("R1/R2 load address", log_addr[n0 + i], a);
            chk("R5 load not a write", {31'd0, log_we[n0 + i]}, 32'd0);
            chk("R5 element value", vrf_m[rg][i], pat(a));
            a = a + {9'd0, strd, 1'b0};
        end
    endtask

    task automatic t_store_wrap;
        int bc;
        int n0;
        logic [15:0] a;
        for (int i = 0; i < 64; i++) vrf_m[3][i] = 16'h3000 + 16'(i * 7);
        mvi(3'b000, 6'd63);
        mvi(3'b001, 6'd5);
        n0 = log_n;
        run(1'b1, 16'h0004, 6'b111100, 3'd3, bc);
        chk("R7 store busy cycles", bc, 26);
        a = 16'hFFFC;
        for (int i = 0; i < 5; i++) begin
            chk("R1/R2 store address wraps", log_addr[n0 + i], a);
            chk("R6 store is a write", {31'd0, log_we[n0 + i]}, 32'd1);
            chk("R6 store data", log_data[n0 + i], 16'h3000 + 16'(i * 7));
            a = a + 16'd126;
        end
    endtask

    task automatic t_bad_select;
        int bc;
        int n0;
        mvi(3'b010, 6'd9);
        mvi(3'b111, 6'd20);
        n0 = log_n;
        run(1'b1, 16'h0100, 6'd0, 3'd3, bc);
        chk("R4 other select leaves count", log_n - n0, 5);
        chk("R4 other select leaves stride", log_addr[n0 + 1], 16'h0100 + 16'd126);
    endtask

    task automatic t_busy_ignore;
        int bc;
        int n0;
        mvi(3'b000, 6'd1);
        mvi(3'b001, 6'd4);
        n0 = log_n;
        @(negedge clk);
        start = 1'b1; op_store = 1'b0; base_addr = 16'h0800; offset = 6'd0; vreg_sel = 3'd5;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        mvi_valid = 1'b1; mvi_sel = 3'b001; mvi_amt = 6'd1;
        start = 1'b1; op_store = 1'b1; vreg_sel = 3'd6; base_addr = 16'h9000;
        @(negedge clk);
        mvi_valid = 1'b0; start = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
        chk("R8 start while busy ignored", log_n - n0, 4);
        chk("R8 direction kept", {31'd0, log_we[n0 + 3]}, 32'd0);
        chk("R4 mvi while busy ignored", log_addr[n0 + 3], 16'h0806);
        n0 = log_n;
        run(1'b0, 16'h0A00, 6'd0, 3'd5, bc);
        chk("R4 count survives busy mvi", bc, 21);
    endtask

    initial begin
        for (int r = 0; r < 8; r++)
            for (int i = 0; i < 64; i++) vrf_m[r][i] = 16'hDEAD;
        t_reset();
        t_zero_count();
        t_load(16'h1000, 6'b111110, 6'd3, 6'd4, 3'd2);
        t_load(16'hFF00, 6'd31, 6'd63, 6'd63, 3'd7);
        t_store_wrap();
        t_bad_select();
        t_busy_ignore();
        mvi(3'b001, 6'd0);
        t_zero_count();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule